// File: doc/BRIEF.md
# Locked-Cycle Write Phase Sequencer

This block is the bus-master controller for the write half of an indivisible read-modify-write transfer on an asynchronous 16-bit bus. The read half has already opened the cycle and left the address strobe low with the address and function codes valid. A one-cycle request, together with a byte selection and write data, starts the write half. The block then walks a fixed chain of half-clock phases, numbered 12 to 19. In those phases it flips the bus direction to write, turns on the data drivers, asserts the chosen data strobes, waits for the cycle to be terminated and finally releases the bus.

The block runs from a clock at twice the bus rate, so one clock period is one phase. Bus termination arrives on three active-low asynchronous inputs: acknowledge, bus error and valid peripheral address. Each passes through a synchronizer before the block looks at it at the decision point that closes phase 16. If nothing has arrived by then, the block adds whole bus clocks (two phases each) until a termination is seen. The outcome of the cycle is reported by a one-cycle flag when the block returns to idle.

Top module: `rmw_write_seq`

## Requirements
- R1: After reset the block is idle: phase_num reads 0, as_n, rw_n, uds_n and lds_n are high, addr_oe and data_oe are low, data_out is 0 and all three outcome flags are low.
- R2: A request made while byte_en is 2'b00 is ignored: phase_num stays 0 and every bus output keeps its idle value.
- R3: A request with a non-zero byte_en makes phase_num read 12 and then 13 in the next two cycles. In both phases addr_oe is high, as_n is low, rw_n is high, both strobes are high and data_oe is low.
- R4: rw_n is low from phase 14 through phase 19 and high in every other phase and in idle.
- R5: data_oe is high and data_out equals the latched write data from phase 15 through phase 19. At all other times data_out is 0.
- R6: From phase 16 through phase 18, including wait phases, uds_n is low when byte_en bit 1 was set at request and lds_n is low when byte_en bit 0 was set. Outside that span both are high.
- R7: ack_n, berr_n and vpa_n each pass through SYNC_STAGES flops. A termination driven low just before clock edge j (the request is edge 0) is acted on with m wait clocks, where m = 0 for j <= 2 and m = (j-2)/2 otherwise, for the default SYNC_STAGES of 2. While waiting, phase_num reads 16 for 2m extra cycles.
- R8: Phase 17 follows the decision and phase 18 follows phase 17. In phase 19, as_n, uds_n and lds_n are high while rw_n stays low. In the cycle after phase 19 the block is idle.
- R9: A cycle ended by acknowledge raises done_ok for exactly the first idle cycle.
- R10: A bus error takes priority over acknowledge and peripheral termination. It ends the cycle through phases 17 to 19 and raises done_err for exactly the first idle cycle.
- R11: A valid-peripheral-address termination with neither acknowledge nor bus error ends the cycle through phases 17 to 19 and raises done_periph for exactly the first idle cycle.
- R12: When acknowledge and peripheral termination are seen together, only done_ok is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Start the write half (accepted in idle) |
| byte_en | input | 2 | Bit 1 selects the upper byte, bit 0 selects the lower byte |
| wr_data | input | DATA_W | Data to write |
| ack_n | input | 1 | Asynchronous data-transfer acknowledge, active low |
| berr_n | input | 1 | Asynchronous bus error, active low |
| vpa_n | input | 1 | Asynchronous valid peripheral address, active low |
| addr_oe | output | 1 | Address and function-code drivers enabled |
| as_n | output | 1 | Address strobe, active low |
| rw_n | output | 1 | High for read, low for write |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| data_oe | output | 1 | Data bus drivers enabled |
| data_out | output | DATA_W | Write data toward the bus |
| phase_num | output | 5 | Current phase number, 0 when idle |
| done_ok | output | 1 | One-cycle pulse: cycle acknowledged |
| done_err | output | 1 | One-cycle pulse: cycle ended by bus error |
| done_periph | output | 1 | One-cycle pulse: cycle ended as a peripheral cycle |

## Verification
The bench builds the block with DATA_W of 16 and SYNC_STAGES of 2. This pins down the synchronizer latency, so the bench can predict the exact number of wait clocks from when it drives a termination. Termination delays range from edge 1 to edge 9. This covers the zero-wait case, the edge exactly at the decision boundary, and up to three whole wait clocks, under all five termination mixes and all three byte selections.

// File: rtl/rmwseq_pkg.sv
// Shared types for the locked-cycle write sequencer.
// Assumes: the state order below is relied on only through case decodes.
package rmwseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S12,
        ST_S13,
        ST_S14,
        ST_S15,
        ST_S16,
        ST_W1,
        ST_W2,
        ST_S17,
        ST_S18,
        ST_S19
    } wr_state_e;

    typedef enum logic [1:0] {
        TM_NONE,
        TM_ACK,
        TM_ERR,
        TM_PER
    } term_e;

endpackage

// File: rtl/rmwseq_sync.sv
// Multi-flop synchronizer for a small vector of active-low async inputs.
// Assumes: inputs idle high; reset loads all stages high (inactive).
module rmwseq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= async_n;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/rmwseq_fsm.sv
// Phase sequencer: steps S12..S19, inserts whole-clock waits (W1/W2 pairs)
// until a synchronized termination is seen, records the termination kind
// and pulses one outcome flag on return to idle.
// Assumes: one clock period equals one bus half-clock phase.
module rmwseq_fsm
    import rmwseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_ok,
    input  logic      ack_s_n,
    input  logic      berr_s_n,
    input  logic      vpa_s_n,
    output wr_state_e state,
    output logic      done_ok,
    output logic      done_err,
    output logic      done_periph
);
    wr_state_e state_nx;
    term_e     term_q;
    logic      decide;
    logic      any_term;

    assign decide   = (state == ST_S16) || (state == ST_W2);
    assign any_term = !ack_s_n || !berr_s_n || !vpa_s_n;

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (req_ok) state_nx = ST_S12;
            ST_S12:  state_nx = ST_S13;
            ST_S13:  state_nx = ST_S14;
            ST_S14:  state_nx = ST_S15;
            ST_S15:  state_nx = ST_S16;
            ST_S16:  state_nx = any_term ? ST_S17 : ST_W1;
            ST_W1:   state_nx = ST_W2;
            ST_W2:   state_nx = any_term ? ST_S17 : ST_W1;
            ST_S17:  state_nx = ST_S18;
            ST_S18:  state_nx = ST_S19;
            ST_S19:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Record the termination kind at the decision point, error first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= TM_NONE;
        end else if (decide && any_term) begin
            if (!berr_s_n)     term_q <= TM_ERR;
            else if (!ack_s_n) term_q <= TM_ACK;
            else               term_q <= TM_PER;
        end
    end

    // One-cycle outcome flags on the exit from S19.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_ok     <= 1'b0;
            done_err    <= 1'b0;
            done_periph <= 1'b0;
        end else begin
            done_ok     <= (state == ST_S19) && (term_q == TM_ACK);
            done_err    <= (state == ST_S19) && (term_q == TM_ERR);
            done_periph <= (state == ST_S19) && (term_q == TM_PER);
        end
    end

    // R10
    err_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && !berr_s_n) |=> (term_q == TM_ERR));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && ack_s_n && berr_s_n && vpa_s_n) |=> (state == ST_W1));

    // R8
    s19_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S19) |=> (state == ST_IDLE));

    // R9
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, done_err, done_periph}));

endmodule

// File: rtl/rmwseq_drive.sv
// Bus output decode: latches byte selection and write data at request,
// then derives every bus control and data output from the current phase.
// Assumes: outputs are decoded from registered state, so they change only
// at the clock edge that begins a phase.
module rmwseq_drive
    import rmwseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_state_e         state,
    input  logic              req_ok,
    input  logic [1:0]        byte_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              addr_oe,
    output logic              as_n,
    output logic              rw_n,
    output logic              uds_n,
    output logic              lds_n,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    output logic [4:0]        phase_num
);
    logic [1:0]        bsel_q;
    logic [DATA_W-1:0] data_q;
    logic              as_on, rw_low, oe_on, strb_on;

    // Capture the request payload when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsel_q <= 2'b00;
            data_q <= '0;
        end else if (state == ST_IDLE && req_ok) begin
            bsel_q <= byte_en;
            data_q <= wr_data;
        end
    end

    // Per-phase control decode.
    always_comb begin
        as_on     = 1'b0;
        rw_low    = 1'b0;
        oe_on     = 1'b0;
        strb_on   = 1'b0;
        phase_num = 5'd0;
        case (state)
            ST_S12: begin as_on = 1'b1; phase_num = 5'd12; end
            ST_S13: begin as_on = 1'b1; phase_num = 5'd13; end
            ST_S14: begin as_on = 1'b1; rw_low = 1'b1; phase_num = 5'd14; end
            ST_S15: begin as_on = 1'b1; rw_low = 1'b1; oe_on = 1'b1; phase_num = 5'd15; end
            ST_S16, ST_W1, ST_W2, ST_S17, ST_S18: begin
                as_on   = 1'b1;
                rw_low  = 1'b1;
                oe_on   = 1'b1;
                strb_on = 1'b1;
                phase_num = (state == ST_S17) ? 5'd17 :
                            (state == ST_S18) ? 5'd18 : 5'd16;
            end
            ST_S19: begin rw_low = 1'b1; oe_on = 1'b1; phase_num = 5'd19; end
            default: ;
        endcase
    end

    assign addr_oe  = (state != ST_IDLE);
    assign as_n     = !as_on;
    assign rw_n     = !rw_low;
    assign data_oe  = oe_on;
    assign data_out = oe_on ? data_q : '0;
    assign uds_n    = !(strb_on && bsel_q[1]);
    assign lds_n    = !(strb_on && bsel_q[0]);

    // R5
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rw_n);

    // R6
    strobe_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!uds_n || !lds_n) |-> (!as_n && data_oe));

    // R3
    as_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S12) |=> (!as_n && addr_oe && rw_n));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S19) |=> (rw_n && !data_oe && !addr_oe));

endmodule

// File: rtl/rmw_write_seq.sv
// Top of the locked-cycle write sequencer: synchronizes the termination
// inputs, runs the phase machine and decodes the bus outputs.
// Assumes: the read half already holds the address strobe low on entry.
module rmw_write_seq #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [1:0]        byte_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_n,
    input  logic              berr_n,
    input  logic              vpa_n,
    output logic              addr_oe,
    output logic              as_n,
    output logic              rw_n,
    output logic              uds_n,
    output logic              lds_n,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    output logic [4:0]        phase_num,
    output logic              done_ok,
    output logic              done_err,
    output logic              done_periph
);
    import rmwseq_pkg::*;

    localparam int TERM_W = 3;

    logic [TERM_W-1:0] term_s_n;
    logic              req_ok;
    wr_state_e         state;

    // A request is only valid with at least one byte lane selected.
    assign req_ok = wr_req && (byte_en != 2'b00);

    rmwseq_sync #(.WIDTH(TERM_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n ({berr_n, ack_n, vpa_n}),
        .sync_n  (term_s_n)
    );

    rmwseq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_ok      (req_ok),
        .ack_s_n     (term_s_n[1]),
        .berr_s_n    (term_s_n[2]),
        .vpa_s_n     (term_s_n[0]),
        .state       (state),
        .done_ok     (done_ok),
        .done_err    (done_err),
        .done_periph (done_periph)
    );

    rmwseq_drive #(.DATA_W(DATA_W)) drive_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .req_ok    (req_ok),
        .byte_en   (byte_en),
        .wr_data   (wr_data),
        .addr_oe   (addr_oe),
        .as_n      (as_n),
        .rw_n      (rw_n),
        .uds_n     (uds_n),
        .lds_n     (lds_n),
        .data_oe   (data_oe),
        .data_out  (data_out),
        .phase_num (phase_num)
    );

    // R2
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_req && byte_en == 2'b00) |=> (phase_num == 5'd0));

endmodule

// File: tb/rmw_write_seq_tb_top.sv
// Self-checking bench: directed corners plus seeded random transactions.
module rmw_write_seq_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_req;
    logic [1:0]    byte_en;
    logic [DW-1:0] wr_data;
    logic          ack_n, berr_n, vpa_n;
    logic          addr_oe, as_n, rw_n, uds_n, lds_n, data_oe;
    logic [DW-1:0] data_out;
    logic [4:0]    phase_num;
    logic          done_ok, done_err, done_periph;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rmw_write_seq #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .byte_en(byte_en),
        .wr_data(wr_data), .ack_n(ack_n), .berr_n(berr_n), .vpa_n(vpa_n),
        .addr_oe(addr_oe), .as_n(as_n), .rw_n(rw_n), .uds_n(uds_n),
        .lds_n(lds_n), .data_oe(data_oe), .data_out(data_out),
        .phase_num(phase_num), .done_ok(done_ok), .done_err(done_err),
        .done_periph(done_periph)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Wait clocks implied by a termination driven before edge j (R7).
    function automatic int exp_waits(input int j);
        return (j <= 2) ? 0 : (j - 2) / 2;
    endfunction

    // Expected phase number after edge i for m wait clocks.
    function automatic int exp_phase(input int i, input int m);
        if (i <= 3)         return 12 + i;
        if (i <= 4 + 2*m)   return 16;
        if (i == 5 + 2*m)   return 17;
        if (i == 6 + 2*m)   return 18;
        if (i == 7 + 2*m)   return 19;
        return 0;
    endfunction

    task automatic chk_idle(input string req);
        chk(phase_num == 0, req, "phase", phase_num, 0);
        chk({as_n, rw_n, uds_n, lds_n} == 4'hF, req, "ctl_n", {as_n, rw_n, uds_n, lds_n}, 15);
        chk({addr_oe, data_oe} == 2'b00, req, "oe", {addr_oe, data_oe}, 0);
        chk(data_out == 0, req, "data", data_out, 0);
    endtask

    // kind: 0 ack, 1 berr, 2 vpa, 3 ack+vpa, 4 berr+ack
    task automatic run_txn(input logic [1:0] bsel, input int j, input int kind,
                           input logic [DW-1:0] dat);
        int m = exp_waits(j);
        wr_req = 1'b1; byte_en = bsel; wr_data = dat;
        @(posedge clk);
        @(negedge clk);
        wr_req = 1'b0; byte_en = 2'b00; wr_data = '0;
        for (int i = 0; i <= 8 + 2*m; i++) begin
            int ph = exp_phase(i, m);
            if (i > 0) @(negedge clk);
            chk(phase_num == ph, (ph >= 16 && ph <= 16) ? "R7" : "R3", "phase", phase_num, ph);
            chk(addr_oe == (ph != 0), "R3", "addr_oe", addr_oe, ph != 0);
            chk(as_n == !(ph >= 12 && ph <= 18), "R8", "as_n", as_n, !(ph >= 12 && ph <= 18));
            chk(rw_n == !(ph >= 14), "R4", "rw_n", rw_n, !(ph >= 14));
            chk(data_oe == (ph >= 15), "R5", "data_oe", data_oe, ph >= 15);
            chk(data_out == ((ph >= 15) ? dat : '0), "R5", "data_out", data_out,
                (ph >= 15) ? dat : 0);
            chk(uds_n == !(ph >= 16 && ph <= 18 && bsel[1]), "R6", "uds_n", uds_n,
                !(ph >= 16 && ph <= 18 && bsel[1]));
            chk(lds_n == !(ph >= 16 && ph <= 18 && bsel[0]), "R6", "lds_n", lds_n,
                !(ph >= 16 && ph <= 18 && bsel[0]));
            if (ph == 0) begin
                chk(done_ok == (kind == 0 || kind == 3), (kind == 3) ? "R12" : "R9",
                    "done_ok", done_ok, kind == 0 || kind == 3);
                chk(done_err == (kind == 1 || kind == 4), "R10", "done_err", done_err,
                    kind == 1 || kind == 4);
                chk(done_periph == (kind == 2), "R11", "done_periph", done_periph, kind == 2);
            end else begin
                chk({done_ok, done_err, done_periph} == 3'b000, "R9", "early_flag",
                    {done_ok, done_err, done_periph}, 0);
            end
            if (i == j - 1) begin
                ack_n  = !(kind == 0 || kind == 3 || kind == 4);
                berr_n = !(kind == 1 || kind == 4);
                vpa_n  = !(kind == 2 || kind == 3);
            end
        end
        ack_n = 1'b1; berr_n = 1'b1; vpa_n = 1'b1;
        @(negedge clk);
        chk({done_ok, done_err, done_periph} == 3'b000, "R9", "flag_one_cycle",
            {done_ok, done_err, done_periph}, 0);
        chk_idle("R8");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        rst_n = 1'b0; wr_req = 1'b0; byte_en = 2'b00; wr_data = '0;
        ack_n = 1'b1; berr_n = 1'b1; vpa_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        chk({done_ok, done_err, done_periph} == 3'b000, "R1", "flags",
            {done_ok, done_err, done_periph}, 0);

        // R2: request with no byte lane is ignored
        wr_req = 1'b1; byte_en = 2'b00; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (2) @(negedge clk);
        chk_idle("R2");

        // Directed corners
        run_txn(2'b11, 1, 0, 16'h1234);   // R9 zero wait
        run_txn(2'b10, 3, 0, 16'hA5A5);   // R7 boundary, no wait
        run_txn(2'b01, 4, 0, 16'h5A5A);   // R7 one wait clock
        run_txn(2'b11, 9, 1, 16'hFFFF);   // R10 three wait clocks
        run_txn(2'b01, 2, 2, 16'h0F0F);   // R11 peripheral
        run_txn(2'b10, 5, 3, 16'h00FF);   // R12 ack beats vpa
        run_txn(2'b11, 6, 4, 16'hC3C3);   // R10 berr beats ack

        // Seeded random transactions
        for (int t = 0; t < 40; t++) begin
            logic [1:0] bs;
            bs = 2'($urandom_range(1, 3));
            run_txn(bs, int'($urandom_range(1, 9)), int'($urandom_range(0, 4)),
                    16'($urandom()));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule